// File: doc/BRIEF.md
# Timer Output Compare Bank

This block holds four 16-bit compare channels that watch a free-running 16-bit timer count supplied from outside. Software reaches each channel's compare value through an 8-bit register bus, one byte per access. When the count equals a channel's value on a cycle in which the count has just advanced, that channel raises a sticky flag and applies a programmed action to its own output pin. The action can leave the pin alone, toggle it, force it low or force it high.

A channel whose action is "no change" still works as plain 16-bit storage, and its flag still reports matches. A 16-bit update is written high byte first, then low byte. Writing a high byte blocks that channel's comparison for the single following cycle, so the half-updated value cannot produce a false match. Two more byte registers complete the map. One holds the four 2-bit action fields. The other shows the flags and clears them when 1s are written to it.

Top module: `tmr_cmp_bank`

## Requirements
- R1: Channel n (n = 1..4) has a 16-bit compare value. Its high byte is at offset 0x14+2n (0x16, 0x18, 0x1A, 0x1C) and its low byte at the next odd offset. Each byte can be written and read back on its own, and writing one byte leaves the other byte unchanged.
- R2: After reset every compare value reads 16'hFFFF, and the action register, the flags and all four pins are 0.
- R3: On a cycle with `tmr_tick` high and `tmr_count` equal to a channel's value, that channel's flag bit is set at the next clock edge. With `tmr_tick` low, no comparison takes place.
- R4: A write to a channel's high byte suppresses that channel's comparison in the next cycle only. A low-byte write does not suppress comparison, and other channels are not affected.
- R5: On the clock edge that ends a matching cycle, the pin applies the channel's action: 00 leaves it unchanged, 01 inverts it, 10 drives it to 0, 11 drives it to 1. With 00 the flag is still set.
- R6: Offset 0x23 reads the flags in bits [3:0] (bit 0 is channel 1) with bits [7:4] as 0. Writing a 1 to a bit clears that flag and writing a 0 leaves it. If a match and a clear reach the same bit in the same cycle, the match wins.
- R7: Offset 0x20 is the action register. Channel n uses bits [2n-1:2n-2], and the register reads back as written.
- R8: Reads of any unmapped offset return 0. Writes to unmapped offsets change no register, flag or pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and timer clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Byte access this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the address |
| tmr_count | input | 16 | Free-running timer count |
| tmr_tick | input | 1 | Count took a new value this cycle |
| cmp_pin | output | 4 | Per-channel output pins |
| cmp_flag | output | 4 | Per-channel sticky match flags |

## Verification
Read data depends combinationally on the address, so the bench samples it within the cycle that drives the read, before the next edge. Each written byte, flag change and pin change appears one edge after the cycle that caused it. The bench therefore drives each stimulus just after a falling edge and samples 1 ns after the rising edge that follows. The inhibit is checked over a three-cycle window: first the high-byte write, then a matching count that must be ignored, then the same count again, which must now set the flag. The bench also checks the pin once before that edge, to confirm that an action does not appear in the matching cycle itself.

// File: rtl/tcb_pkg.sv
package tcb_pkg;

    localparam int TCB_NUM_CH    = 4;
    localparam int TCB_BYTE_W    = 8;
    localparam int TCB_CNT_W     = 16;
    localparam int TCB_ADDR_W    = 8;
    localparam int TCB_CMP_BASE  = 'h16;
    localparam int TCB_ACT_OFS   = 'h20;
    localparam int TCB_FLAG_OFS  = 'h23;

    typedef enum logic [1:0] {
        PIN_KEEP   = 2'b00,
        PIN_TOGGLE = 2'b01,
        PIN_CLEAR  = 2'b10,
        PIN_SET    = 2'b11
    } pin_act_e;

    // Offset of a channel's high byte; its low byte is the next offset.
    function automatic int hi_ofs(input int base, input int ch);
        return base + 2 * ch;
    endfunction

    // Pin level after a match, for a given action and current level.
    function automatic logic pin_next(input pin_act_e act, input logic cur);
        logic nxt;
        unique case (act)
            PIN_KEEP:   nxt = cur;
            PIN_TOGGLE: nxt = ~cur;
            PIN_CLEAR:  nxt = 1'b0;
            PIN_SET:    nxt = 1'b1;
            default:    nxt = cur;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/tcb_regfile.sv
module tcb_regfile
    import tcb_pkg::*;
#(
    parameter int NUM_CH   = TCB_NUM_CH,
    parameter int BYTE_W   = TCB_BYTE_W,
    parameter int ADDR_W   = TCB_ADDR_W,
    parameter int CMP_BASE = TCB_CMP_BASE
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              wr_en,
    input  logic [ADDR_W-1:0]                 addr,
    input  logic [BYTE_W-1:0]                 wdata,
    output logic [NUM_CH-1:0][2*BYTE_W-1:0]   cmp_val,
    output logic [NUM_CH-1:0]                 inhibit,
    output logic [BYTE_W-1:0]                 rd_byte,
    output logic                              rd_hit
);

    localparam int CNT_W = 2 * BYTE_W;

    logic [NUM_CH-1:0] hi_wr;
    logic [NUM_CH-1:0] lo_wr;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        localparam logic [ADDR_W-1:0] HI_A = ADDR_W'(hi_ofs(CMP_BASE, g));
        localparam logic [ADDR_W-1:0] LO_A = ADDR_W'(hi_ofs(CMP_BASE, g) + 1);

        assign hi_wr[g] = wr_en && (addr == HI_A);
        assign lo_wr[g] = wr_en && (addr == LO_A);

        always_ff @(posedge clk) begin
            if (rst) begin
                cmp_val[g] <= '1;
                inhibit[g] <= 1'b0;
            end else begin
                inhibit[g] <= hi_wr[g];
                if (hi_wr[g]) cmp_val[g][CNT_W-1:BYTE_W] <= wdata;
                if (lo_wr[g]) cmp_val[g][BYTE_W-1:0]     <= wdata;
            end
        end

        // R2
        reset_ffff_chk: assert property (@(posedge clk) disable iff (rst)
            $past(rst) |-> (cmp_val[g] == {CNT_W{1'b1}}));

        // R1
        lo_keeps_hi_chk: assert property (@(posedge clk) disable iff (rst)
            (lo_wr[g] && !hi_wr[g]) |=> $stable(cmp_val[g][CNT_W-1:BYTE_W]));
    end

    always_comb begin
        rd_byte = '0;
        rd_hit  = 1'b0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (addr == ADDR_W'(hi_ofs(CMP_BASE, i))) begin
                rd_byte = cmp_val[i][CNT_W-1:BYTE_W];
                rd_hit  = 1'b1;
            end
            if (addr == ADDR_W'(hi_ofs(CMP_BASE, i) + 1)) begin
                rd_byte = cmp_val[i][BYTE_W-1:0];
                rd_hit  = 1'b1;
            end
        end
    end

endmodule

// File: rtl/tcb_channel.sv
module tcb_channel
    import tcb_pkg::*;
#(
    parameter int CNT_W = TCB_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] count,
    input  logic             tick,
    input  logic [CNT_W-1:0] cmp_val,
    input  logic             inhibit,
    input  pin_act_e         action,
    input  logic             flag_clr,
    output logic             fire,
    output logic             flag,
    output logic             pin
);

    assign fire = tick && !inhibit && (count == cmp_val);

    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= 1'b0;
            pin  <= 1'b0;
        end else begin
            if (fire)          flag <= 1'b1;
            else if (flag_clr) flag <= 1'b0;
            if (fire)          pin  <= pin_next(action, pin);
        end
    end

    // R3
    match_sets_flag_chk: assert property (@(posedge clk) disable iff (rst)
        fire |=> flag);

    // R6
    flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (flag && !flag_clr) |=> flag);

    // R5
    pin_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !fire |=> $stable(pin));

    // R5
    pin_set_chk: assert property (@(posedge clk) disable iff (rst)
        (fire && action == PIN_SET) |=> pin);

    // R5
    pin_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (fire && action == PIN_CLEAR) |=> !pin);

    // R5
    pin_toggle_chk: assert property (@(posedge clk) disable iff (rst)
        (fire && action == PIN_TOGGLE) |=> (pin != $past(pin)));

endmodule

// File: rtl/tmr_cmp_bank.sv
module tmr_cmp_bank
    import tcb_pkg::*;
#(
    parameter int NUM_CH   = TCB_NUM_CH,
    parameter int BYTE_W   = TCB_BYTE_W,
    parameter int ADDR_W   = TCB_ADDR_W,
    parameter int CMP_BASE = TCB_CMP_BASE,
    parameter int ACT_OFS  = TCB_ACT_OFS,
    parameter int FLAG_OFS = TCB_FLAG_OFS
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_valid,
    input  logic                bus_write,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [BYTE_W-1:0]   bus_wdata,
    output logic [BYTE_W-1:0]   bus_rdata,
    input  logic [2*BYTE_W-1:0] tmr_count,
    input  logic                tmr_tick,
    output logic [NUM_CH-1:0]   cmp_pin,
    output logic [NUM_CH-1:0]   cmp_flag
);

    // The action fields share one byte: NUM_CH must not exceed BYTE_W/2.
    localparam int CNT_W = 2 * BYTE_W;
    localparam int ACT_W = 2 * NUM_CH;
    localparam logic [ADDR_W-1:0] ACT_A  = ADDR_W'(ACT_OFS);
    localparam logic [ADDR_W-1:0] FLAG_A = ADDR_W'(FLAG_OFS);

    logic                          wr_en;
    logic                          rd_en;
    logic [NUM_CH-1:0][CNT_W-1:0]  cmp_val;
    logic [NUM_CH-1:0]             inhibit;
    logic [BYTE_W-1:0]             rf_byte;
    logic                          rf_hit;
    logic [ACT_W-1:0]              act_q;
    logic [NUM_CH-1:0]             flag_clr;
    logic [NUM_CH-1:0]             fire;

    assign wr_en = bus_valid && bus_write;
    assign rd_en = bus_valid && !bus_write;

    tcb_regfile #(
        .NUM_CH   (NUM_CH),
        .BYTE_W   (BYTE_W),
        .ADDR_W   (ADDR_W),
        .CMP_BASE (CMP_BASE)
    ) i_regfile (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .addr    (bus_addr),
        .wdata   (bus_wdata),
        .cmp_val (cmp_val),
        .inhibit (inhibit),
        .rd_byte (rf_byte),
        .rd_hit  (rf_hit)
    );

    always_ff @(posedge clk) begin
        if (rst)                               act_q <= '0;
        else if (wr_en && bus_addr == ACT_A)   act_q <= bus_wdata[ACT_W-1:0];
    end

    assign flag_clr = (wr_en && bus_addr == FLAG_A) ? bus_wdata[NUM_CH-1:0] : '0;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        localparam logic [ADDR_W-1:0] HI_A = ADDR_W'(hi_ofs(CMP_BASE, g));

        tcb_channel #(
            .CNT_W (CNT_W)
        ) i_chan (
            .clk      (clk),
            .rst      (rst),
            .count    (tmr_count),
            .tick     (tmr_tick),
            .cmp_val  (cmp_val[g]),
            .inhibit  (inhibit[g]),
            .action   (pin_act_e'(act_q[2*g +: 2])),
            .flag_clr (flag_clr[g]),
            .fire     (fire[g]),
            .flag     (cmp_flag[g]),
            .pin      (cmp_pin[g])
        );

        // R4
        hi_write_blocks_chk: assert property (@(posedge clk) disable iff (rst)
            $past(bus_valid && bus_write && bus_addr == HI_A) |-> !fire[g]);
    end

    always_comb begin
        bus_rdata = '0;
        if (rd_en) begin
            if (rf_hit)                  bus_rdata = rf_byte;
            else if (bus_addr == ACT_A)  bus_rdata = BYTE_W'(act_q);
            else if (bus_addr == FLAG_A) bus_rdata = BYTE_W'(cmp_flag);
        end
    end

    // R8
    idle_bus_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !bus_valid |-> (bus_rdata == '0));

endmodule

// File: tb/test_tmr_cmp_bank.sv
module test_tmr_cmp_bank;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [15:0] tmr_count = '0;
    logic        tmr_tick = 1'b0;
    logic [3:0]  cmp_pin;
    logic [3:0]  cmp_flag;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    tmr_cmp_bank i_tmr_cmp_bank (
        .clk       (clk),
        .rst       (rst),
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .tmr_count (tmr_count),
        .tmr_tick  (tmr_tick),
        .cmp_pin   (cmp_pin),
        .cmp_flag  (cmp_flag)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One cycle: drive after falling edge, sample 1 ns after rising edge.
    task automatic cyc(input logic v, input logic w, input logic [7:0] a,
                       input logic [7:0] d, input logic [15:0] cnt, input logic tk);
        @(negedge clk);
        bus_valid = v; bus_write = w; bus_addr = a; bus_wdata = d;
        tmr_count = cnt; tmr_tick = tk;
        @(posedge clk);
        #1;
        bus_valid = 1'b0; bus_write = 1'b0; tmr_tick = 1'b0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        cyc(1'b1, 1'b1, a, d, 16'h0, 1'b0);
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a; tmr_tick = 1'b0;
        #1;
        d = bus_rdata;
        @(posedge clk);
        #1;
        bus_valid = 1'b0;
    endtask

    task automatic wr16(input int ch, input logic [15:0] v);
        wr(8'(8'h14 + 2 * ch), v[15:8]);
        wr(8'(8'h15 + 2 * ch), v[7:0]);
    endtask

    task automatic chk_rd(input string req, input logic [7:0] a, input logic [7:0] exp);
        logic [7:0] d;
        rd(a, d);
        chk(req, {24'h0, d}, {24'h0, exp});
    endtask

    task automatic chk16(input string req, input int ch, input logic [15:0] exp);
        chk_rd(req, 8'(8'h14 + 2 * ch), exp[15:8]);
        chk_rd(req, 8'(8'h15 + 2 * ch), exp[7:0]);
    endtask

    function automatic bit mapped(input int a);
        return (a >= 'h16 && a <= 'h1D) || a == 'h20 || a == 'h23;
    endfunction

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : main
        logic [15:0] pats [4];
        logic [7:0]  d;
        pats[0] = 16'h0000; pats[1] = 16'hA5C3; pats[2] = 16'h5A3C; pats[3] = 16'hFFFE;

        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #1;

        // R2: reset state
        chk("R2 pins", {28'h0, cmp_pin}, 32'h0);
        chk("R2 flags", {28'h0, cmp_flag}, 32'h0);
        for (int ch = 1; ch <= 4; ch++) chk16("R2 cmp reset", ch, 16'hFFFF);
        chk_rd("R2 action reset", 8'h20, 8'h00);
        chk_rd("R2 flag reg reset", 8'h23, 8'h00);

        // R1: byte read/write sweep across channels and patterns
        for (int p = 0; p < 4; p++) begin
            for (int ch = 1; ch <= 4; ch++) wr16(ch, pats[p] ^ 16'(ch * 16'h1111));
            for (int ch = 1; ch <= 4; ch++) chk16("R1 readback", ch, pats[p] ^ 16'(ch * 16'h1111));
        end
        // R1: single-byte writes leave the other half
        wr16(2, 16'h1234);
        wr(8'h19, 8'hEE);
        chk16("R1 low only", 2, 16'h12EE);
        wr(8'h18, 8'h77);
        chk16("R1 high only", 2, 16'h77EE);

        // Known values for the compare tests
        for (int ch = 1; ch <= 4; ch++) wr16(ch, 16'(ch * 16'h1000));

        // R8: unmapped writes ignored, unmapped reads zero
        for (int a = 0; a < 256; a++) begin
            if (!mapped(a)) begin
                wr(8'(a), 8'h5A);
                chk_rd("R8 unmapped read", 8'(a), 8'h00);
            end
        end
        for (int ch = 1; ch <= 4; ch++) chk16("R8 cmp untouched", ch, 16'(ch * 16'h1000));
        chk_rd("R8 action untouched", 8'h20, 8'h00);
        chk("R8 flags untouched", {28'h0, cmp_flag}, 32'h0);
        chk("R8 pins untouched", {28'h0, cmp_pin}, 32'h0);

        // R3: no compare without tick, match with tick
        cyc(1'b0, 1'b0, 8'h0, 8'h0, 16'h1000, 1'b0);
        chk("R3 no tick", {28'h0, cmp_flag}, 32'h0);
        cyc(1'b0, 1'b0, 8'h0, 8'h0, 16'h0FFF, 1'b1);
        chk("R3 no equal", {28'h0, cmp_flag}, 32'h0);
        for (int ch = 1; ch <= 4; ch++) begin
            cyc(1'b0, 1'b0, 8'h0, 8'h0, 16'(ch * 16'h1000), 1'b1);
            chk("R3 match flag", {28'h0, cmp_flag}, 32'(1 << (ch - 1)));
            wr(8'h23, 8'h0F);
            chk("R6 clear all", {28'h0, cmp_flag}, 32'h0);
        end

        // R7: action register; ch1 toggle, ch2 low, ch3 high, ch4 keep
        wr(8'h20, 8'h39);
        chk_rd("R7 action readback", 8'h20, 8'h39);

        // R5: action appears only after the matching edge
        @(negedge clk);
        tmr_count = 16'h3000; tmr_tick = 1'b1;
        #1;
        chk("R5 pin not yet", {28'h0, cmp_pin}, 32'h0);
        @(posedge clk); #1; tmr_tick = 1'b0;
        chk("R5 set high", {28'h0, cmp_pin}, 32'h4);
        cyc(1'b0, 1'b0, 8'h0, 8'h0, 16'h1000, 1'b1);
        chk("R5 toggle up", {28'h0, cmp_pin}, 32'h5);
        cyc(1'b0, 1'b0, 8'h0, 8'h0, 16'h1000, 1'b1);
        chk("R5 toggle down", {28'h0, cmp_pin}, 32'h4);
        wr(8'h20, 8'h3D);
        cyc(1'b0, 1'b0, 8'h0, 8'h0, 16'h2000, 1'b1);
        chk("R5 ch2 high", {28'h0, cmp_pin}, 32'h6);
        wr(8'h20, 8'h39);
        cyc(1'b0, 1'b0, 8'h0, 8'h0, 16'h2000, 1'b1);
        chk("R5 drive low", {28'h0, cmp_pin}, 32'h4);
        wr(8'h23, 8'h0F);
        cyc(1'b0, 1'b0, 8'h0, 8'h0, 16'h4000, 1'b1);
        chk("R5 keep pin", {28'h0, cmp_pin}, 32'h4);
        chk("R5 keep still flags", {28'h0, cmp_flag}, 32'h8);
        chk16("R5 storage value", 4, 16'h4000);
        wr(8'h23, 8'h0F);

        // R4: high-byte write blocks the next cycle only
        cyc(1'b1, 1'b1, 8'h16, 8'h55, 16'h0000, 1'b1);
        cyc(1'b0, 1'b0, 8'h0, 8'h0, 16'h5500, 1'b1);
        chk("R4 inhibited", {28'h0, cmp_flag}, 32'h0);
        cyc(1'b0, 1'b0, 8'h0, 8'h0, 16'h5500, 1'b1);
        chk("R4 one cycle only", {28'h0, cmp_flag}, 32'h1);
        wr(8'h23, 8'h01);
        cyc(1'b1, 1'b1, 8'h17, 8'h66, 16'h0000, 1'b1);
        cyc(1'b0, 1'b0, 8'h0, 8'h0, 16'h5566, 1'b1);
        chk("R4 low write no inhibit", {28'h0, cmp_flag}, 32'h1);
        wr(8'h23, 8'h01);
        cyc(1'b1, 1'b1, 8'h18, 8'h20, 16'h3000, 1'b1);
        chk("R4 other channel same cycle", {28'h0, cmp_flag}, 32'h4);
        cyc(1'b0, 1'b0, 8'h0, 8'h0, 16'h2000, 1'b1);
        chk("R4 ch2 inhibited", {28'h0, cmp_flag}, 32'h4);
        wr(8'h23, 8'h0F);

        // R6: set wins over clear; 0 bits do not clear; upper bits read 0
        cyc(1'b1, 1'b1, 8'h23, 8'h01, 16'h5566, 1'b1);
        chk("R6 set wins", {28'h0, cmp_flag}, 32'h1);
        cyc(1'b0, 1'b0, 8'h0, 8'h0, 16'h3000, 1'b1);
        chk("R6 two flags", {28'h0, cmp_flag}, 32'h5);
        wr(8'h23, 8'h04);
        chk("R6 partial clear", {28'h0, cmp_flag}, 32'h1);
        chk_rd("R6 flag read", 8'h23, 8'h01);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule